// File: doc/BRIEF.md
# Trailing Zero Counter

This block reports how many zero bits lie below the lowest set bit of a 32-bit word. It first reduces the word to a one-hot vector that marks only that lowest set bit. This vector is the word ANDed with its two's-complement negation. Each bit of the count is then taken from one masked OR-reduction of that vector. No bit-by-bit priority chain is used. An all-zero word gives the full width, 32.

A word handed in with its valid strobe comes back as a 6-bit count with a valid strobe one clock later. A parameter removes the output register when a purely combinational path is wanted. If the word is known to be a power of two, the count is its exponent, so the block also serves as an exponent finder. A second parameter picks which of two equivalent encodings drives the output. The sum-of-masks form sets the count bits one by one. The descending form starts from 31 and subtracts halving steps.

Top module: `trail_zero_count`

## Requirements
- R1: An all-zero input word produces a count of 32.
- R2: A nonzero input word produces the bit index of its lowest set bit, whatever the bits above it hold.
- R3: An input that is an exact power of two produces its exponent; for example 8 gives 3, 32 gives 5 and 0x80000000 gives 31.
- R4: Count bit 5 is 1 only for the all-zero input, and count bits 4..0 are all 0 in that case.
- R5: With the output registered (default), `outValid` is high in exactly the cycle after each cycle in which `inValid` was high at a rising clock edge, and low otherwise.
- R6: In a cycle where `inValid` is low, `outCount` keeps its previous value, whatever `inData` carries.
- R7: A synchronous active-high `rst` clears `outValid` and `outCount` to 0 at the next rising edge, even when `inValid` is high in the same cycle.
- R8: The sum-of-masks encoding and the descending-subtraction encoding give the same count for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inData` as a word to encode |
| inData | input | 32 | Word whose trailing zeros are counted |
| outValid | output | 1 | Marks `outCount` as a fresh result |
| outCount | output | 6 | Trailing-zero count, 0 to 32 |

## Verification
The reset clear and the loading of a new word can fall in the same cycle. This happens when `rst` and `inValid` are both high at one edge. The bench forces this collision with a nonzero word whose count would differ from 0. It then judges that the next cycle shows both the valid strobe and the count cleared, so reset wins. The bench also checks that a word offered with the strobe low leaves the held count untouched. The agreement of the two encodings is checked on every cycle outside reset.

// File: rtl/tzc_pkg.sv
package tzc_pkg;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;   // capture the freshly encoded count
    logic clear;  // force the count register to zero
  } tzcStrobes_t;

endpackage

// File: rtl/tzc_ctrl.sv
module tzc_ctrl
  import tzc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output tzcStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid && !rst;
  end

  generate
    if (REG_OUT) begin : gRegValid
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : gCombValid
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/tzc_datapath.sv
module tzc_datapath
  import tzc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit REG_OUT      = 1'b1,
  parameter bit USE_SUB_FORM = 1'b0,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  tzcStrobes_t       strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [CNT_W-1:0]  outCount,
  output logic [CNT_W-1:0]  sumCount,
  output logic [CNT_W-1:0]  subCount
);

  // bit i of the mask is set when bit k of index i is set
  function automatic logic [DATA_W-1:0] oddMask(input int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> k) & 1) == 1;
    return m;
  endfunction

  logic [DATA_W-1:0] isolated;
  logic              nonZero;
  logic [IDX_W-1:0]  deductBits;
  logic [CNT_W-1:0]  subStart;
  logic [CNT_W-1:0]  nextCount;

  assign isolated = inData & (~inData + DATA_W'(1));
  assign nonZero  = |inData;

  // sum form: each count bit is one masked reduction
  genvar k;
  generate
    for (k = 0; k < IDX_W; k++) begin : gSumBit
      assign sumCount[k] = |(isolated & oddMask(k));
    end
  endgenerate
  assign sumCount[IDX_W] = ~nonZero;

  // descending form: start from the top index and remove halving steps
  generate
    for (k = 0; k < IDX_W; k++) begin : gSubStep
      assign deductBits[k] = |(isolated & ~oddMask(k));
    end
  endgenerate
  assign subStart = nonZero ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
  assign subCount = subStart - {1'b0, deductBits};

  generate
    if (USE_SUB_FORM) begin : gPickSub
      assign nextCount = subCount;
    end else begin : gPickSum
      assign nextCount = sumCount;
    end
  endgenerate

  generate
    if (REG_OUT) begin : gRegCount
      logic [CNT_W-1:0] countQ;
      always_ff @(posedge clk) begin
        if (strobes.clear)     countQ <= '0;
        else if (strobes.load) countQ <= nextCount;
      end
      assign outCount = countQ;
    end else begin : gCombCount
      assign outCount = nextCount;
    end
  endgenerate

endmodule

// File: rtl/trail_zero_count.sv
module trail_zero_count
  import tzc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit REG_OUT      = 1'b1,
  parameter bit USE_SUB_FORM = 1'b0,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [CNT_W-1:0]  outCount
);

  tzcStrobes_t      strobes;
  logic [CNT_W-1:0] sumCount;
  logic [CNT_W-1:0] subCount;

  tzc_ctrl #(.REG_OUT(REG_OUT)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  tzc_datapath #(
    .DATA_W       (DATA_W),
    .REG_OUT      (REG_OUT),
    .USE_SUB_FORM (USE_SUB_FORM)
  ) dp_i (
    .clk      (clk),
    .strobes  (strobes),
    .inData   (inData),
    .outCount (outCount),
    .sumCount (sumCount),
    .subCount (subCount)
  );

endmodule

// File: rtl/tzc_checker.sv
module tzc_checker #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [CNT_W-1:0] outCount,
  input logic [CNT_W-1:0] sumCount,
  input logic [CNT_W-1:0] subCount
);

  AST_FORMS_AGREE: assert property (@(posedge clk) disable iff (rst)
    sumCount == subCount); // R8

  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    outValid && outCount[CNT_W-1] |-> outCount[CNT_W-2:0] == '0); // R4

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outCount <= CNT_W'(DATA_W)); // R1

  generate
    if (REG_OUT) begin : gRegChecks
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        inValid |=> outValid); // R5

      AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> !outValid); // R5

      AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> $stable(outCount)); // R6

      AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !outValid && outCount == '0); // R7
    end
  endgenerate

endmodule

bind trail_zero_count tzc_checker #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outCount (outCount),
  .sumCount (sumCount),
  .subCount (subCount)
);

// File: tb/trail_zero_count_tb_top.sv
module trail_zero_count_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        outValid;
  logic [5:0]  outCount;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trail_zero_count dut_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outCount (outCount)
  );

  // word and expected count
  localparam logic [37:0] VEC [12] = '{
    {32'h0000_0000, 6'd32}, {32'h0000_0001, 6'd0},  {32'h0000_0008, 6'd3},
    {32'h0000_0020, 6'd5},  {32'h8000_0000, 6'd31}, {32'hFFFF_FFFF, 6'd0},
    {32'hFFFF_0000, 6'd16}, {32'h0000_A000, 6'd13}, {32'h00F0_0000, 6'd20},
    {32'h7FFF_FFFE, 6'd1},  {32'h8000_0001, 6'd0},  {32'h0C00_0000, 6'd26}
  };

  function automatic int refCount(input logic [31:0] w);
    for (int i = 0; i < 32; i++) if (w[i]) return i;
    return 32;
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runWord(input logic [31:0] w, input int exp);
    string tag;
    if (w == 0)                tag = "R1";
    else if ((w & (w - 1)) == 0) tag = "R3";
    else                       tag = "R2";
    @(negedge clk);
    inValid = 1'b1;
    inData  = w;
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R5 valid after accept", int'(outValid), 1);
    checkEq(tag, int'(outCount), exp);
    checkEq("R4 full-width flag", int'(outCount[5]), int'(w == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    int held;
    repeat (3) @(negedge clk);
    checkEq("R7 reset valid", int'(outValid), 0);
    checkEq("R7 reset count", int'(outCount), 0);
    rst = 1'b0;

    foreach (VEC[i]) runWord(VEC[i][37:6], int'(VEC[i][5:0]));

    for (int b = 0; b < 33; b++) begin
      logic [31:0] w;
      w = (b < 32) ? (32'h1 << b) : 32'h0;
      runWord(w, refCount(w));
    end

    lcg = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      runWord(lcg & (lcg << (n % 20)), refCount(lcg & (lcg << (n % 20))));
    end

    // R6: word offered without strobe leaves count untouched
    runWord(32'h0000_0400, 10);
    held = int'(outCount);
    @(negedge clk);
    inData = 32'h0000_0001;
    @(negedge clk);
    checkEq("R6 no valid", int'(outValid), 0);
    checkEq("R6 count held", int'(outCount), held);

    // R5: back-to-back words produce back-to-back results
    @(negedge clk);
    inValid = 1'b1;
    inData  = 32'h0000_0100;
    @(negedge clk);
    inData  = 32'h0000_0000;
    checkEq("R5 first of pair valid", int'(outValid), 1);
    checkEq("R2 first of pair", int'(outCount), 8);
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R5 second of pair valid", int'(outValid), 1);
    checkEq("R1 second of pair", int'(outCount), 32);
    @(negedge clk);
    checkEq("R5 strobe drops", int'(outValid), 0);

    // R7: reset and load in the same cycle, reset wins
    runWord(32'h0000_0040, 6);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    inData = 32'h0000_0002;
    @(negedge clk);
    checkEq("R7 collision valid", int'(outValid), 0);
    checkEq("R7 collision count", int'(outCount), 0);
    rst = 1'b0;
    inValid = 1'b0;
    runWord(32'h0000_0002, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule